// File: doc/BRIEF.md
# Synchronous Differential Clock Stop Gate

This block takes one source clock and drives a set of true/complement clock pairs from it. An asynchronous active-low stop request freezes every pair, and releasing the request starts them again. The request is synchronised on rising edges of the source clock. The gating point only moves while the source clock is low. Because of this, the true output of a pair only ever shows whole high phases of the source clock. It never shows a shortened or lengthened pulse when it stops or restarts.

A stopped pair parks with its true output low and its complement output high. The complement is always the exact inverse of the gated true output. Each pair has its own drive-enable output, taken from an enable input, which tells the pad ring to drive that pair or to float it. A separate reference clock passes straight through with its own enable. The stop request never touches it.

Top module: `clk_stop_gate`

## Requirements
- R1: While the gate is open, the true output of every pair is high during each high phase of `src_clk_i` and low during each low phase.
- R2: `stop_n_i` (0 = stop, 1 = run) is sampled on rising edges of `src_clk_i`. Suppose it changes between two rising edges. The high phases that start at the first and second rising edges after the change still follow the old state. The high phase that starts at the third rising edge is the first one that follows the new state.
- R3: While stopped, every true output is held at 0 and every complement output at 1.
- R4: At every instant, each complement output is the bitwise inverse of its true output.
- R5: Restarting follows the same three-edge latency as stopping. Every high pulse on a true output lasts exactly one full high phase of `src_clk_i`, with no runt or stretched pulse.
- R6: `pair_oe_o[k]` equals `pair_en_i[k]` (1 = drive, 0 = high impedance). The enables have no effect on the clock values.
- R7: `ref_clk_o` follows `ref_clk_i` and `ref_oe_o` follows `ref_en_i`, whatever the state of `stop_n_i`.
- R8: While `rst_n` is low, and afterwards until a stop request has passed the synchroniser, the gate is open and the pairs run, even if `stop_n_i` is held at 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Source clock to be gated |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_n_i | input | 1 | Asynchronous stop request, 0 = stop |
| pair_en_i | input | NUM_PAIRS | Per-pair drive enable |
| ref_clk_i | input | 1 | Free-running reference clock |
| ref_en_i | input | 1 | Reference drive enable |
| clk_t_o | output | NUM_PAIRS | True clock outputs |
| clk_c_o | output | NUM_PAIRS | Complement clock outputs |
| pair_oe_o | output | NUM_PAIRS | Per-pair drive enable, 0 = high impedance |
| ref_clk_o | output | 1 | Reference clock output |
| ref_oe_o | output | 1 | Reference drive enable, 0 = high impedance |

## Verification
The assertions check three things on every cycle. The gate state never changes during a high phase of the source clock. A closed gate parks every pair low/high and an open gate passes every high phase. Two consecutive stop or run samples always leave the gate in the matching state by the next rising edge. The bench's scenarios cover the rest. They show the exact three-edge latency in both directions and that reset overrides a held stop request. They also measure the width of every true-output high pulse in time and show that the enables and the reference path stay independent of the stop request.

// File: rtl/clkgate_pkg.sv
// Package: shared defaults for the clock stop gate.
// Assumes: nothing beyond IEEE 1800-2017.
package clkgate_pkg;
    parameter int unsigned DEF_PAIRS = 3;   // true/complement pairs
    parameter int unsigned DEF_SYNC  = 2;   // rising-edge samples of the stop request
    typedef enum logic {GATE_SHUT = 1'b0, GATE_OPEN = 1'b1} gate_e;
endpackage

// File: rtl/stop_sync.sv
// Module: stop_sync
// Brings the asynchronous active-low stop request into the source clock
// domain through STAGES rising-edge flops. Assumes the request is level-held
// for at least STAGES cycles. Resets to "run" so reset overrides a stop.
module stop_sync #(
    parameter int unsigned STAGES = clkgate_pkg::DEF_SYNC
) (
    input  logic src_clk_i,
    input  logic rst_n,
    input  logic stop_n_i,
    output logic run_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: sample the raw request.
                always_ff @(posedge src_clk_i) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= stop_n_i;
                end
            end else begin : g_next
                // Later stages: shift the sampled value along.
                always_ff @(posedge src_clk_i) begin
                    if (!rst_n) chain_q[s] <= 1'b1;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign run_o = chain_q[LAST];
endmodule

// File: rtl/gate_ctl.sv
// Module: gate_ctl
// Holds the gate state and updates it only on the falling edge of the source
// clock, so the state is frozen across every high phase. Assumes run_i
// changes only just after rising edges.
module gate_ctl
    import clkgate_pkg::*;
(
    input  logic  src_clk_i,
    input  logic  rst_n,
    input  logic  run_i,
    output gate_e gate_o
);
    gate_e gate_q;
    gate_e gate_at_rise_q;

    // Gate state: move only while the source clock is about to go low.
    always_ff @(negedge src_clk_i) begin
        if (!rst_n) gate_q <= GATE_OPEN;
        else        gate_q <= run_i ? GATE_OPEN : GATE_SHUT;
    end

    // Copy of the gate taken at each rising edge, used only by the check.
    always_ff @(posedge src_clk_i) begin
        gate_at_rise_q <= gate_q;
    end

    // R5
    full_phase_chk: assert property (@(negedge src_clk_i) disable iff (!rst_n)
        gate_q == gate_at_rise_q)
        else $error("gate moved during a high phase");

    assign gate_o = gate_q;
endmodule

// File: rtl/pair_drive.sv
// Module: pair_drive
// Forms the true/complement pairs from the source clock and the gate state,
// and passes the per-pair drive enables. Assumes the gate only changes while
// the source clock is low.
module pair_drive
    import clkgate_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = DEF_PAIRS
) (
    input  logic                 src_clk_i,
    input  logic                 rst_n,
    input  gate_e                gate_i,
    input  logic [NUM_PAIRS-1:0] en_i,
    output logic [NUM_PAIRS-1:0] clk_t_o,
    output logic [NUM_PAIRS-1:0] clk_c_o,
    output logic [NUM_PAIRS-1:0] oe_o
);
    localparam logic [NUM_PAIRS-1:0] ALL_ONE = {NUM_PAIRS{1'b1}};

    generate
        for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
            // Per pair: gated true clock, its inverse, and its drive enable.
            always_comb begin
                clk_t_o[k] = src_clk_i & (gate_i == GATE_OPEN);
                clk_c_o[k] = ~clk_t_o[k];
                oe_o[k]    = en_i[k];
            end
        end
    endgenerate

    // R3
    park_state_chk: assert property (@(negedge src_clk_i) disable iff (!rst_n)
        (gate_i == GATE_SHUT) |-> (clk_t_o == '0 && clk_c_o == ALL_ONE))
        else $error("stopped pair not parked");

    // R1
    pass_high_chk: assert property (@(negedge src_clk_i) disable iff (!rst_n)
        (gate_i == GATE_OPEN) |-> (clk_t_o == ALL_ONE && clk_c_o == '0))
        else $error("open gate did not pass high phase");
endmodule

// File: rtl/clk_stop_gate.sv
// Module: clk_stop_gate (top)
// Stops and restarts NUM_PAIRS true/complement clock pairs under an
// active-low stop request without runt or stretched pulses, and passes a
// reference clock and all drive enables through. Assumes a single source
// clock for all pairs.
module clk_stop_gate
    import clkgate_pkg::*;
#(
    parameter int unsigned NUM_PAIRS   = DEF_PAIRS,
    parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
    input  logic                 src_clk_i,
    input  logic                 rst_n,
    input  logic                 stop_n_i,
    input  logic [NUM_PAIRS-1:0] pair_en_i,
    input  logic                 ref_clk_i,
    input  logic                 ref_en_i,
    output logic [NUM_PAIRS-1:0] clk_t_o,
    output logic [NUM_PAIRS-1:0] clk_c_o,
    output logic [NUM_PAIRS-1:0] pair_oe_o,
    output logic                 ref_clk_o,
    output logic                 ref_oe_o
);
    logic  run_s;
    gate_e gate_s;

    stop_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .src_clk_i (src_clk_i),
        .rst_n     (rst_n),
        .stop_n_i  (stop_n_i),
        .run_o     (run_s)
    );

    gate_ctl i_gate (
        .src_clk_i (src_clk_i),
        .rst_n     (rst_n),
        .run_i     (run_s),
        .gate_o    (gate_s)
    );

    pair_drive #(.NUM_PAIRS(NUM_PAIRS)) i_pairs (
        .src_clk_i (src_clk_i),
        .rst_n     (rst_n),
        .gate_i    (gate_s),
        .en_i      (pair_en_i),
        .clk_t_o   (clk_t_o),
        .clk_c_o   (clk_c_o),
        .oe_o      (pair_oe_o)
    );

    // Reference path: untouched by the stop logic.
    always_comb begin
        ref_clk_o = ref_clk_i;
        ref_oe_o  = ref_en_i;
    end

    // Edge counter since reset, so latency checks never look before reset.
    logic [1:0] edges_q;
    always_ff @(posedge src_clk_i) begin
        if (!rst_n)              edges_q <= 2'd0;
        else if (edges_q != 2'd3) edges_q <= edges_q + 2'd1;
    end

    generate
        if (SYNC_STAGES == 2) begin : g_lat_chk
            // R2
            stop_after_two_chk: assert property (@(posedge src_clk_i) disable iff (!rst_n)
                (edges_q == 2'd3 && !$past(stop_n_i) && !$past(stop_n_i, 2)) |-> (gate_s == GATE_SHUT))
                else $error("stop not applied after two samples");
            // R5
            run_after_two_chk: assert property (@(posedge src_clk_i) disable iff (!rst_n)
                (edges_q == 2'd3 && $past(stop_n_i) && $past(stop_n_i, 2)) |-> (gate_s == GATE_OPEN))
                else $error("run not applied after two samples");
        end
    endgenerate
endmodule

// File: tb/test_clk_stop_gate.sv
module test_clk_stop_gate;
    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stop_n = 1'b1;
    logic [NP-1:0] en = '1;
    logic          ref_clk = 1'b0;
    logic          ref_en = 1'b1;
    logic [NP-1:0] t_o, c_o, oe_o;
    logic          ref_o, ref_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;     // 125 MHz
    always #7 ref_clk = ~ref_clk;

    clk_stop_gate i_clk_stop_gate (
        .src_clk_i (clk),   .rst_n (rst_n), .stop_n_i (stop_n),
        .pair_en_i (en),    .ref_clk_i (ref_clk), .ref_en_i (ref_en),
        .clk_t_o   (t_o),   .clk_c_o (c_o), .pair_oe_o (oe_o),
        .ref_clk_o (ref_o), .ref_oe_o (ref_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Move to the middle of the next high phase.
    task automatic hi_mid();
        @(posedge clk); #2;
    endtask

    // Move to just after the next rising edge, to change inputs.
    task automatic drive_pt();
        @(posedge clk); #1;
    endtask

    // Full pair check in a high phase: run=1 expects t all 1.
    task automatic pair_chk(input bit run, input string req);
        logic [NP-1:0] et;
        et = run ? '1 : '0;
        chk(t_o == et, req, {29'd0, t_o}, {29'd0, et});
        chk(c_o == ~t_o, "R4", {29'd0, c_o}, {29'd0, ~t_o});
    endtask

    // Pulse-width monitor on true output 0 (R5): each high pulse lasts 4 ns.
    realtime rise_t = -1.0;
    bit      mon_on = 1'b0;
    always @(posedge t_o[0]) rise_t = $realtime;
    always @(negedge t_o[0]) begin
        if (mon_on && rise_t >= 0.0)
            chk(($realtime - rise_t) == 4.0, "R5 pulse width",
                32'($rtoi($realtime - rise_t)), 32'd4);
    end

    // Vector table: [4]=stop_n, [3:1]=pair enables, [0]=ref enable.
    localparam int NV = 6;
    localparam logic [4:0] VEC [NV] = '{
        5'b1_111_1, 5'b1_010_0, 5'b0_111_1, 5'b0_001_0, 5'b1_100_1, 5'b1_000_1
    };

    bit wd_hit = 1'b0;
    initial begin
        #200000;
        wd_hit = 1'b1;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // Reset with stop held low: gate must stay open (R8).
        stop_n = 1'b0;
        repeat (3) hi_mid();
        pair_chk(1'b1, "R8 in reset");
        drive_pt(); rst_n = 1'b1;
        hi_mid(); pair_chk(1'b1, "R8 after release");
        hi_mid(); hi_mid(); hi_mid();
        pair_chk(1'b0, "R3 held stop after reset");
        chk(c_o == '1, "R3", {29'd0, c_o}, 32'd7);
        drive_pt(); stop_n = 1'b1;
        repeat (4) hi_mid();
        mon_on = 1'b1;

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            drive_pt();
            stop_n = VEC[v][4]; en = VEC[v][3:1]; ref_en = VEC[v][0];
            repeat (4) hi_mid();
            pair_chk(VEC[v][4], VEC[v][4] ? "R1 table" : "R3 table");
            chk(oe_o == VEC[v][3:1], "R6", {29'd0, oe_o}, {29'd0, VEC[v][3:1]});
            chk(ref_oe == VEC[v][0], "R7 oe", {31'd0, ref_oe}, {31'd0, VEC[v][0]});
            chk(ref_o == ref_clk, "R7 clk", {31'd0, ref_o}, {31'd0, ref_clk});
        end

        // Exact stop latency (R2): old state for two high phases, new on third.
        drive_pt(); stop_n = 1'b0;
        hi_mid(); pair_chk(1'b1, "R2 stop edge1");
        hi_mid(); pair_chk(1'b1, "R2 stop edge2");
        hi_mid(); pair_chk(1'b0, "R2 stop edge3");
        #4; chk(t_o == '0 && c_o == '1, "R3 low phase", {29'd0, t_o}, 32'd0);
        // Reference keeps running while stopped (R7).
        for (int i = 0; i < 6; i++) begin
            #3; chk(ref_o == ref_clk, "R7 while stopped", {31'd0, ref_o}, {31'd0, ref_clk});
        end

        // Exact restart latency (R5).
        drive_pt(); stop_n = 1'b1;
        hi_mid(); pair_chk(1'b0, "R5 run edge1");
        hi_mid(); pair_chk(1'b0, "R5 run edge2");
        hi_mid(); pair_chk(1'b1, "R5 run edge3");
        #4; chk(t_o == '0, "R1 low phase", {29'd0, t_o}, 32'd0);

        // Short stop pulse of one cycle still yields whole pulses (R5).
        drive_pt(); stop_n = 1'b0;
        drive_pt(); stop_n = 1'b1;
        repeat (6) hi_mid();
        pair_chk(1'b1, "R5 after short stop");

        if (!wd_hit) begin
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule